// File: doc/BRIEF.md
# I2C Word-Register Target

This block is an I2C target that gives an external I2C controller access to a small bank of 32-bit registers. The block answers to a 7-bit address supplied on a port. After addressing, the first written data byte selects a register. The next four written bytes are collected least-significant byte first and stored into that register as one word. When the controller reads, the selected register comes back one byte at a time, again least-significant byte first.

Inside the block, SCL and SDA are synchronised and their edges detected. A bit engine then shifts bytes in and out and drives ACK. Above it, a protocol state machine tracks the register index, the byte position and the word being built. A register bank holds the words, and a parallel port lets local logic read any register. SDA is never driven high: the block only pulls it low through an enable. If a transaction stalls for a programmable number of system clocks while the bus is busy, the protocol state is reset.

Top module: `i2c_word_target`

## Requirements
- R1: The target ACKs an address byte only when its upper seven bits equal `tgt_addr` (bit 0 is R/W, 1 = read). After a non-matching address, every following byte is left unacknowledged and no register changes until the next START.
- R2: With the protocol state idle, the first data byte written after a matching address is taken as the register index.
- R3: The four data bytes that follow the index are packed least-significant byte first, and the word is written to the selected register when the fourth byte arrives. `rb_data` shows the register chosen by `rb_idx` in the same cycle.
- R4: The register selected is the index modulo NUM_REGS: index 10 selects register 2 when NUM_REGS is 8.
- R5: A controller read returns the selected register's bytes least-significant byte first. A repeated START after an index write keeps the index, so a read can follow.
- R6: After four bytes have been read, the protocol state is idle, and any further byte read in that transaction is 0xFF.
- R7: When the controller NACKs a read byte, the protocol state returns to idle, so the next written byte is taken as an index.
- R8: Every data byte written while the target is addressed is acknowledged.
- R9: A register index written in one transaction, followed by STOP, selects the register for a read in the next transaction.
- R10: If the bus is busy and no address or data byte completes for TIMEOUT_CYC clocks, the protocol and bit engine return to idle. The next written byte after a new address is then taken as an index.
- R11: After reset every register reads 0 and SDA is released (`sda_oe` = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tgt_addr | input | 7 | 7-bit target address |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| rb_idx | input | IDX_W | Local read-back register select |
| rb_data | output | 32 | Contents of the register selected by `rb_idx` |

## Verification
The bench acts as an I2C controller on a wired-AND SDA line. It goes after the cases where state left over from one transaction can silently corrupt the next.

- A design that ignored a controller NACK would count the abandoned read bytes into the next write and commit a word to the wrong register.
- A design without the stall timeout would do the same after a hung transfer.
- A design that reset the index on STOP or repeated START would read back the wrong register.
- A design that kept going after four read bytes would return real data instead of 0xFF.
- A design with the byte order reversed would return swapped words.

// File: rtl/i2c_word_pkg.sv
// Shared types for the I2C word-register target.
// Assumes: used by the bit engine, the top-level protocol FSM and the checker.
package i2c_word_pkg;

    // Protocol level: where the byte stream is within an index/word sequence.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INDEX = 2'd1,
        ST_DATA  = 2'd2
    } proto_st_e;

    // Bit level: what the bit engine is doing on the wire.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_RX    = 3'd1,
        PH_ACK   = 3'd2,
        PH_TX    = 3'd3,
        PH_TXACK = 3'd4
    } bit_ph_e;

endpackage

// File: rtl/i2c_word_bitphy.sv
// I2C target bit engine.
// Synchronises SCL/SDA through two flops, detects START/STOP and SCL edges.
// Shifts address/data bytes in, drives ACK, and shifts read bytes out MSB first.
// Assumes: SCL high and low times span several system clocks; no clock stretching.
module i2c_word_bitphy
    import i2c_word_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] own_addr,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [7:0] tx_byte,
    input  logic       abort,
    output logic       sda_oe,
    output logic       rx_vld,
    output logic [7:0] rx_byte,
    output logic       tx_take,
    output logic       tx_nack,
    output logic       addr_hit,
    output logic       bus_start,
    output logic       bus_stop
);

    logic [1:0] scl_q, sda_q;
    logic       scl_d, sda_d;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall;
    bit_ph_e    phase;
    logic [7:0] shreg;
    logic [3:0] bitcnt;
    logic       is_addr;
    logic       rd_mode;
    logic       nack_q;

    // Two-flop synchronisers plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 2'b11;
            sda_q <= 2'b11;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[0], scl_in};
            sda_q <= {sda_q[0], sda_in};
            scl_d <= scl_q[1];
            sda_d <= sda_q[1];
        end
    end

    assign scl_s     = scl_q[1];
    assign sda_s     = sda_q[1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
    assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

    // Bit-level state machine: receive, acknowledge, transmit, sample controller ACK.
    always_ff @(posedge clk) begin
        rx_vld   <= 1'b0;
        tx_take  <= 1'b0;
        tx_nack  <= 1'b0;
        addr_hit <= 1'b0;
        if (!rst_n) begin
            phase   <= PH_IDLE;
            shreg   <= '0;
            bitcnt  <= '0;
            is_addr <= 1'b0;
            rd_mode <= 1'b0;
            nack_q  <= 1'b0;
            sda_oe  <= 1'b0;
            rx_byte <= '0;
        end else if (abort) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
        end else if (bus_start) begin
            phase   <= PH_RX;
            is_addr <= 1'b1;
            bitcnt  <= '0;
            sda_oe  <= 1'b0;
        end else if (bus_stop) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (phase)
                PH_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        if (is_addr) begin
                            is_addr <= 1'b0;
                            if (shreg[7:1] == own_addr) begin
                                addr_hit <= 1'b1;
                                rd_mode  <= shreg[0];
                                phase    <= PH_ACK;
                                sda_oe   <= 1'b1;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else begin
                            rx_vld  <= 1'b1;
                            rx_byte <= shreg;
                            phase   <= PH_ACK;
                            sda_oe  <= 1'b1;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rd_mode) begin
                            shreg   <= tx_byte;
                            sda_oe  <= ~tx_byte[7];
                            tx_take <= 1'b1;
                            phase   <= PH_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            phase  <= PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            phase  <= PH_TXACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                PH_TXACK: begin
                    if (scl_rise) begin
                        nack_q <= sda_s;
                    end else if (scl_fall) begin
                        bitcnt <= '0;
                        if (nack_q) begin
                            tx_nack <= 1'b1;
                            phase   <= PH_IDLE;
                        end else begin
                            shreg   <= tx_byte;
                            sda_oe  <= ~tx_byte[7];
                            tx_take <= 1'b1;
                            phase   <= PH_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2c_word_regs.sv
// Register bank of NUM_REGS 32-bit words.
// One write port and two combinational read ports (I2C transmit and local read-back).
// Assumes: indices at or above NUM_REGS read as zero.
module i2c_word_regs #(
    parameter int NUM_REGS = 8,
    parameter int DW       = 32,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] raddr_a,
    output logic [DW-1:0]    rdata_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [DW-1:0]    rdata_b
);

    logic [DW-1:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        // Storage for one word, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (we && waddr == IDX_W'(g)) begin
                mem[g] <= wdata;
            end
        end
    end

    // Read multiplexers for both ports.
    always_comb begin
        rdata_a = '0;
        rdata_b = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr_a == IDX_W'(i)) rdata_a = mem[i];
            if (raddr_b == IDX_W'(i)) rdata_b = mem[i];
        end
    end

endmodule

// File: rtl/i2c_word_target.sv
// I2C target exposing NUM_REGS 32-bit registers.
// First written byte selects a register; four more bytes form a word, LSB first.
// Reads return the selected word LSB first; a bus stall of TIMEOUT_CYC clocks resets the protocol.
// Assumes: single controller, 7-bit addressing, no clock stretching.
module i2c_word_target
    import i2c_word_pkg::*;
#(
    parameter int  NUM_REGS    = 8,
    parameter int  TIMEOUT_CYC = 100000,
    localparam int IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [6:0]       tgt_addr,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [31:0]      rb_data
);

    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    proto_st_e        st;
    logic [7:0]       reg_idx;
    logic [1:0]       byte_cnt;
    logic [31:0]      acc;
    logic [31:0]      acc_nx;
    logic [IDX_W-1:0] sel;
    logic [31:0]      sel_word;
    logic [7:0]       tx_byte;
    logic             reg_we;
    logic             busy;
    logic [TW-1:0]    tmo_cnt;
    logic             tmo_fire;
    logic             rx_vld, tx_take, tx_nack, addr_hit, bus_start, bus_stop;
    logic [7:0]       rx_byte;

    i2c_word_bitphy u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_addr  (tgt_addr),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .tx_byte   (tx_byte),
        .abort     (tmo_fire),
        .sda_oe    (sda_oe),
        .rx_vld    (rx_vld),
        .rx_byte   (rx_byte),
        .tx_take   (tx_take),
        .tx_nack   (tx_nack),
        .addr_hit  (addr_hit),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_word_regs #(
        .NUM_REGS (NUM_REGS),
        .DW       (32),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .waddr   (sel),
        .wdata   (acc_nx),
        .raddr_a (sel),
        .rdata_a (sel_word),
        .raddr_b (rb_idx),
        .rdata_b (rb_data)
    );

    assign sel      = IDX_W'(32'(reg_idx) % NUM_REGS);
    assign acc_nx   = acc | (32'(rx_byte) << {byte_cnt, 3'b000});
    assign reg_we   = rx_vld && (st != ST_IDLE) && (byte_cnt == 2'd3) && !tmo_fire;
    assign tx_byte  = (st == ST_IDLE) ? 8'hFF : sel_word[{byte_cnt, 3'b000} +: 8];
    assign tmo_fire = busy && (tmo_cnt == TW'(TIMEOUT_CYC));

    // Bus-busy flag: set by START, cleared by STOP or by a stall timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || tmo_fire) begin
            busy <= 1'b0;
        end else if (bus_start) begin
            busy <= 1'b1;
        end else if (bus_stop) begin
            busy <= 1'b0;
        end
    end

    // Stall counter: restarts on any completed byte, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy || bus_start || rx_vld || tx_take || addr_hit) begin
            tmo_cnt <= '0;
        end else if (tmo_cnt != TW'(TIMEOUT_CYC)) begin
            tmo_cnt <= tmo_cnt + TW'(1);
        end
    end

    // Protocol FSM: index capture, word assembly and read byte sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            reg_idx  <= '0;
            byte_cnt <= '0;
            acc      <= '0;
        end else if (tmo_fire || tx_nack) begin
            st <= ST_IDLE;
        end else if (rx_vld) begin
            if (st == ST_IDLE) begin
                reg_idx  <= rx_byte;
                byte_cnt <= '0;
                acc      <= '0;
                st       <= ST_INDEX;
            end else begin
                acc      <= acc_nx;
                byte_cnt <= byte_cnt + 2'd1;
                st       <= (byte_cnt == 2'd3) ? ST_IDLE : ST_DATA;
            end
        end else if (tx_take && st != ST_IDLE) begin
            byte_cnt <= byte_cnt + 2'd1;
            st       <= (byte_cnt == 2'd3) ? ST_IDLE : ST_DATA;
        end
    end

endmodule

// File: rtl/i2c_word_target_chk.sv
// Protocol checker for i2c_word_target, attached with bind.
// Assumes: signals are sampled on the rising clock edge after reset release.
module i2c_word_target_chk
    import i2c_word_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000,
    parameter int TW          = 17
) (
    input logic          clk,
    input logic          rst_n,
    input proto_st_e     st,
    input logic          rx_vld,
    input logic          tx_take,
    input logic          tx_nack,
    input logic          addr_hit,
    input logic          reg_we,
    input logic          tmo_fire,
    input logic          busy,
    input logic          sda_oe,
    input logic [TW-1:0] tmo_cnt
);

    // R1
    addr_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> busy);

    // R2
    index_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && st == ST_IDLE && !tmo_fire) |=> st == ST_INDEX);

    // R3
    commit_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> st == ST_IDLE);

    // R5
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_vld, tx_take, tx_nack}));

    // R7
    nack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_nack |=> st == ST_IDLE);

    // R8
    data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |-> sda_oe);

    // R10
    timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_fire |=> (st == ST_IDLE && !busy));

    // R10
    timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_cnt <= TW'(TIMEOUT_CYC));

endmodule

bind i2c_word_target i2c_word_target_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .TW          (TW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .rx_vld   (rx_vld),
    .tx_take  (tx_take),
    .tx_nack  (tx_nack),
    .addr_hit (addr_hit),
    .reg_we   (reg_we),
    .tmo_fire (tmo_fire),
    .busy     (busy),
    .sda_oe   (sda_oe),
    .tmo_cnt  (tmo_cnt)
);

// File: tb/i2c_word_target_tb.sv
// Self-checking bench: acts as an I2C controller on a wired-AND SDA line.
module i2c_word_target_tb;

    localparam int         Q      = 20;
    localparam logic [6:0] TADDR  = 7'h2A;
    localparam logic [7:0] AW     = {TADDR, 1'b0};
    localparam logic [7:0] AR     = {TADDR, 1'b1};
    localparam int         TMO    = 1500;

    // Vector: {index byte, word to write}
    localparam logic [39:0] VEC [4] = '{
        {8'd0,  32'h1122_3344},
        {8'd5,  32'hDEAD_BEEF},
        {8'd10, 32'hCAFE_0001},
        {8'd7,  32'h8001_7FFE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [2:0]  rb_idx = '0;
    logic [31:0] rb_data;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    logic        done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_word_target #(.NUM_REGS(8), .TIMEOUT_CYC(TMO)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt_addr (TADDR),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .rb_idx   (rb_idx),
        .rb_data  (rb_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2 * Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b = {b[6:0], sda_line}; wq(Q);
            scl_m = 1'b0;
        end
        wq(Q);
        sda_m = give_ack ? 1'b0 : 1'b1; wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic wr_txn(input logic [7:0] idx, input logic [31:0] w, output logic all_ack);
        logic a;
        bus_start();
        wbyte(AW, a);  all_ack = a;
        wbyte(idx, a); all_ack &= a;
        for (int k = 0; k < 4; k++) begin
            wbyte(w[8*k +: 8], a);
            all_ack &= a;
        end
        bus_stop();
    endtask

    task automatic rd_txn(input logic [7:0] idx, input int n, output logic [39:0] data);
        logic a;
        logic [7:0] b;
        data = '0;
        bus_start();
        wbyte(AW, a);
        wbyte(idx, a);
        bus_start();
        wbyte(AR, a);
        for (int k = 0; k < n; k++) begin
            rbyte(k != n - 1, b);
            data[8*k +: 8] = b;
        end
        bus_stop();
    endtask

    task automatic peek(input logic [2:0] idx, output logic [31:0] d);
        rb_idx = idx;
        @(negedge clk);
        d = rb_data;
    endtask

    initial begin
        logic        ok;
        logic        a;
        logic [7:0]  b;
        logic [31:0] d;
        logic [39:0] rd;

        wq(5);
        // R11: reset state
        check("R11 sda released", {39'd0, sda_oe}, 40'd0);
        peek(3'd0, d); check("R11 reg0 zero", {8'd0, d}, 40'd0);
        peek(3'd7, d); check("R11 reg7 zero", {8'd0, d}, 40'd0);
        rst_n = 1'b1;
        wq(5);

        // Vector table: write then read back locally and over I2C (R2, R3, R4, R5, R8)
        for (int v = 0; v < 4; v++) begin
            wr_txn(VEC[v][39:32], VEC[v][31:0], ok);
            check("R8 write txn all bytes ACKed", {39'd0, ok}, 40'd1);
            peek(3'(VEC[v][39:32] % 8), d);
            check("R2 R3 R4 word at index mod 8", {8'd0, d}, {8'd0, VEC[v][31:0]});
            rd_txn(VEC[v][39:32], 4, rd);
            check("R5 read LSB first after repeated START", rd, {8'd0, VEC[v][31:0]});
        end

        // R1: wrong address is ignored, no ACK, no register change
        bus_start();
        wbyte({7'h2B, 1'b0}, a); ok = a;
        wbyte(8'h00, a); ok |= a;
        wbyte(8'hAA, a); ok |= a;
        wbyte(8'hBB, a); ok |= a;
        bus_stop();
        check("R1 no ACK for other address", {39'd0, ok}, 40'd0);
        peek(3'd0, d);
        check("R1 reg0 unchanged", {8'd0, d}, 40'h00_1122_3344);

        // R6: fifth read byte after four is 0xFF
        rd_txn(8'd5, 5, rd);
        check("R6 four bytes then 0xFF", rd, 40'hFF_DEAD_BEEF);

        // R7: early NACK returns to idle
        rd_txn(8'd0, 2, rd);
        check("R7 partial read", rd, 40'h00_0000_3344);
        wr_txn(8'd3, 32'h0403_0201, ok);
        peek(3'd3, d);
        check("R7 next byte is index after NACK", {8'd0, d}, 40'h00_0403_0201);
        peek(3'd0, d);
        check("R7 reg0 untouched", {8'd0, d}, 40'h00_1122_3344);

        // R9: index survives STOP
        bus_start();
        wbyte(AW, a);
        wbyte(8'd7, a);
        bus_stop();
        bus_start();
        wbyte(AR, a);
        rbyte(1'b0, b);
        bus_stop();
        check("R9 index kept across STOP", {32'd0, b}, 40'hFE);

        // R10: stall timeout resets protocol state
        bus_start();
        wbyte(AW, a);
        wbyte(8'd4, a);
        wbyte(8'h55, a);
        wbyte(8'h66, a);
        wq(2000);
        bus_stop();
        wr_txn(8'd6, 32'hA4A3_A2A1, ok);
        check("R10 ACKs after timeout", {39'd0, ok}, 40'd1);
        peek(3'd6, d);
        check("R10 new index honoured", {8'd0, d}, 40'h00_A4A3_A2A1);
        peek(3'd4, d);
        check("R10 stalled word discarded", {8'd0, d}, 40'd0);

        check("R11 sda released at end", {39'd0, sda_oe}, 40'd0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule